// File: doc/BRIEF.md
# Programmable Chip-Select Unit

This block sits between a 32-bit bus master and a set of slow external devices: SRAM, EPROM, flash and memory-mapped peripherals. It compares each strobed address against eight programmable banks and drives the chip-select line of the winning bank. It then counts that bank's wait states and answers the master with a one-cycle data acknowledge. With the acknowledge it reports the port width of the selected device.

Each bank has two registers: a base register and an option register. The base register holds a compare address and a valid flag. The option register holds an address mask, a port-width code and a wait-state count from 0 to 15.

Bank 0 doubles as the boot select. From reset it answers every address, using reset-time timing defaults, so that code can be fetched before any setup. It keeps answering every address until software writes its base register.

Top module: `csel_unit`

## Requirements
- R1: While reset is held, and right after it is released, every chip select and the acknowledge are low.
- R2: After reset, bank 0 matches every address. Its wait count is 15 and its port code is 16-bit until its option register is written.
- R3: Writing bank 0's option register leaves the match-all behaviour in place. The first write to bank 0's base register ends it for good.
- R4: Each bank has two registers, selected by `cfg_addr[3:1]` for the bank and `cfg_addr[0]` for the register (0 = base, 1 = option).
  - Base register: address in bits 31:12, valid flag in bit 0.
  - Option register: mask in bits 31:12, port code in bits 5:4, wait count in bits 3:0.
  - A bank matches when it is valid and `bus_addr[31:12]` equals the base on every bit where the mask is 1.
- R5: When several banks match, the lowest-numbered bank is selected.
- R6: A strobed address that matches no bank raises no chip select and no acknowledge for as long as the strobe is held.
- R7: The strobe is first sampled high at clock edge 1. The chip select rises after edge 1. The acknowledge is high for exactly one cycle, after edge 2+W, where W is the bank's wait count. So zero wait states gives a two-clock access.
- R8: While the acknowledge is high, `port_size` gives the selected bank's port code: 01 = 8-bit, 10 = 16-bit, 00 = 32-bit. The code 11 is reported as 00.
- R9: The chip select stays high until the edge at which the strobe is sampled low, and is low after that edge. If the strobe drops before the acknowledge, the access ends and no acknowledge is given.
- R10: At most one chip select is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Bank (bits 3:1) and register select (bit 0) |
| cfg_wdata | input | 32 | Register write data |
| bus_addr | input | 32 | Master address |
| bus_strobe | input | 1 | Master address strobe, held high for the access |
| cs | output | 8 | Active-high chip selects, one per bank |
| ack | output | 1 | One-cycle data acknowledge |
| port_size | output | 2 | Port width code of the selected bank |

## Verification
A corrupted wait counter shows up directly at the acknowledge: it arrives a number of cycles too early or too late, or never arrives, within at most 17 cycles of the strobe. A wrong boot flag or a wrong bank register shows up one cycle after the strobe, as the wrong chip select or no chip select at all. A state machine stuck after the acknowledge shows up in two ways: the chip select stays high past the strobe's release, or the next access is never selected.

// File: rtl/csel_unit.sv
module csel_unit #(
  parameter int NB = 8,
  parameter int AW = 32,
  parameter int CMP_LSB = 12,
  parameter logic [3:0] BOOT_WAIT = 4'd15,
  parameter logic [1:0] BOOT_PORT = 2'b10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [$clog2(NB):0]    cfg_addr,
  input  logic [AW-1:0]          cfg_wdata,
  input  logic [AW-1:0]          bus_addr,
  input  logic                   bus_strobe,
  output logic [NB-1:0]          cs,
  output logic                   ack,
  output logic [1:0]             port_size
);
  localparam int BW = $clog2(NB);
  localparam int CW = AW - CMP_LSB;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} st_t;

  logic [CW-1:0] base_q [NB];
  logic [CW-1:0] mask_q [NB];
  logic [3:0]    wait_q [NB];
  logic [1:0]    port_q [NB];
  logic [NB-1:0] vld_q;
  logic          boot_q;
  logic [NB-1:0] hit;
  logic [BW-1:0] win;
  logic          any_hit;
  st_t           st_q;
  logic [3:0]    cnt_q;

  wire [BW-1:0] wr_bank = cfg_addr[BW:1];
  wire          wr_opt  = cfg_addr[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      vld_q  <= '0;
      for (int i = 0; i < NB; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
        wait_q[i] <= (i == 0) ? BOOT_WAIT : 4'd0;
        port_q[i] <= (i == 0) ? BOOT_PORT : 2'b00;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < NB; i++) begin
        if (int'(wr_bank) == i) begin
          if (wr_opt) begin
            mask_q[i] <= cfg_wdata[AW-1:CMP_LSB];
            port_q[i] <= cfg_wdata[5:4];
            wait_q[i] <= cfg_wdata[3:0];
          end else begin
            base_q[i] <= cfg_wdata[AW-1:CMP_LSB];
            vld_q[i]  <= cfg_wdata[0];
          end
        end
      end
      if (!wr_opt && wr_bank == '0) boot_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_cmp
    wire eq = ((bus_addr[AW-1:CMP_LSB] ^ base_q[g]) & mask_q[g]) == '0;
    if (g == 0) begin : g_boot
      assign hit[g] = boot_q | (vld_q[g] & eq);
    end else begin : g_std
      assign hit[g] = vld_q[g] & eq;
    end
  end

  assign any_hit = |hit;

  always_comb begin
    win = '0;
    for (int i = NB - 1; i >= 0; i--)
      if (hit[i]) win = BW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cs        <= '0;
      ack       <= 1'b0;
      cnt_q     <= '0;
      port_size <= 2'b00;
    end else begin
      case (st_q)
        S_IDLE: begin
          ack <= 1'b0;
          if (bus_strobe && any_hit) begin
            cs        <= NB'(1) << win;
            cnt_q     <= wait_q[win];
            port_size <= (port_q[win] == 2'b11) ? 2'b00 : port_q[win];
            st_q      <= S_RUN;
          end
        end
        S_RUN: begin
          if (!bus_strobe) begin
            cs   <= '0;
            st_q <= S_IDLE;
          end else if (cnt_q == 4'd0) begin
            ack  <= 1'b1;
            st_q <= S_HOLD;
          end else begin
            cnt_q <= cnt_q - 4'd1;
          end
        end
        default: begin
          ack <= 1'b0;
          if (!bus_strobe) begin
            cs   <= '0;
            st_q <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

module csel_unit_chk #(
  parameter int NB = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_strobe,
  input logic [NB-1:0] cs,
  input logic          ack
);
  assert_onehot_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs));

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_ack_with_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ($countones(cs) == 1 && $past(|cs)));

  assert_cs_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |=> (cs == '0));

  assert_no_ack_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_strobe && cs == '0) |=> !ack);
endmodule

bind csel_unit csel_unit_chk #(.NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .cs(cs), .ack(ack)
);

// File: tb/sim_csel_unit.sv
module sim_csel_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] bus_addr = '0;
  logic        bus_strobe = 1'b0;
  logic [7:0]  cs;
  logic        ack;
  logic [1:0]  port_size;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  csel_unit u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .bus_strobe(bus_strobe),
    .cs(cs), .ack(ack), .port_size(port_size)
  );

  // {addr, expected bank (8 = none), wait, port code}
  localparam logic [41:0] VEC [0:8] = '{
    {32'h000A_BCDE, 4'd0, 4'd2,  2'b10},
    {32'h0010_0000, 4'd8, 4'd0,  2'b00},
    {32'h1000_0004, 4'd1, 4'd0,  2'b00},
    {32'h1000_1234, 4'd1, 4'd0,  2'b00},
    {32'h2000_0FFC, 4'd3, 4'd15, 2'b00},
    {32'h2000_1000, 4'd8, 4'd0,  2'b00},
    {32'h3ABC_0000, 4'd7, 4'd1,  2'b01},
    {32'h4000_0010, 4'd8, 4'd0,  2'b00},
    {32'h4FFF_FFFF, 4'd8, 4'd0,  2'b00}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int bank, input bit opt, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {3'(bank), opt}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic [31:0] a, input int bank, input int w,
                        input logic [1:0] psz, input string req);
    logic [7:0] exp_cs;
    bit bad;
    exp_cs = (bank < 8) ? (8'd1 << bank) : 8'd0;
    @(negedge clk);
    bus_addr = a; bus_strobe = 1'b1;
    @(posedge clk); @(negedge clk);
    check(cs == exp_cs && !ack, req, "cs after strobe", {24'd0, cs}, {24'd0, exp_cs});
    if (bank < 8) begin
      bad = 1'b0;
      for (int n = 2; n < 2 + w; n++) begin
        @(posedge clk); @(negedge clk);
        if (ack || cs != exp_cs) bad = 1'b1;
      end
      check(!bad, "R7", "early ack or cs loss", {31'd0, bad}, 32'd0);
      @(posedge clk); @(negedge clk);
      check(ack && cs == exp_cs, "R7", "ack after wait states", {31'd0, ack}, 32'd1);
      check(port_size == psz, "R8", "port size", {30'd0, port_size}, {30'd0, psz});
      @(posedge clk); @(negedge clk);
      check(!ack && cs == exp_cs, "R9", "ack one cycle, cs held", {23'd0, ack, cs}, {24'd0, exp_cs});
    end else begin
      bad = 1'b0;
      for (int n = 0; n < 20; n++) begin
        @(posedge clk); @(negedge clk);
        if (ack || cs != 0) bad = 1'b1;
      end
      check(!bad, "R6", "unmatched access responded", {31'd0, bad}, 32'd0);
    end
    bus_strobe = 1'b0;
    @(posedge clk); @(negedge clk);
    check(cs == 0 && !ack, "R9", "cs after strobe release", {24'd0, cs}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cs == 0 && !ack, "R1", "reset outputs", {23'd0, ack, cs}, 32'd0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check(cs == 0 && !ack, "R1", "after reset release", {23'd0, ack, cs}, 32'd0);

    access(32'hDEAD_BEEF, 0, 15, 2'b10, "R2");
    access(32'h7000_0000, 0, 15, 2'b10, "R2");

    // R3: option write keeps match-all, base write ends it
    wr(0, 1'b1, 32'hFFF0_0000 | (2'b10 << 4) | 4'd2);
    access(32'h5000_0000, 0, 2, 2'b10, "R3");
    wr(0, 1'b0, 32'h0000_0001);
    wr(1, 1'b0, 32'h1000_0001); wr(1, 1'b1, 32'hFF00_0000 | (2'b00 << 4) | 4'd0);
    wr(2, 1'b0, 32'h1000_0001); wr(2, 1'b1, 32'hFFFF_0000 | (2'b01 << 4) | 4'd5);
    wr(3, 1'b0, 32'h2000_0001); wr(3, 1'b1, 32'hFFFF_F000 | (2'b11 << 4) | 4'd15);
    wr(7, 1'b0, 32'h3000_0001); wr(7, 1'b1, 32'hF000_0000 | (2'b01 << 4) | 4'd1);
    wr(4, 1'b0, 32'h4000_0000); wr(4, 1'b1, 32'hFFF0_0000);
    access(32'h5000_0000, 8, 0, 2'b00, "R3");

    // R4, R5, R6, R7, R8 table
    for (int i = 0; i < 9; i++)
      access(VEC[i][41:10], int'(VEC[i][9:6]), int'(VEC[i][5:2]), VEC[i][1:0], "R4");

    // R5: with bank 1 invalid, bank 2 takes the overlap
    wr(1, 1'b0, 32'h1000_0000);
    access(32'h1000_1234, 2, 5, 2'b01, "R5");
    access(32'h1001_0000, 8, 0, 2'b00, "R6");

    // R9: strobe dropped before ack aborts the access
    @(negedge clk);
    bus_addr = 32'h2000_0000; bus_strobe = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(cs == 8'h08 && !ack, "R9", "cs mid access", {24'd0, cs}, 32'h08);
    bus_strobe = 1'b0;
    @(posedge clk); @(negedge clk);
    check(cs == 0, "R9", "cs after abort", {24'd0, cs}, 32'd0);
    begin
      bit seen = 1'b0;
      for (int n = 0; n < 20; n++) begin
        @(posedge clk); @(negedge clk);
        if (ack || cs != 0) seen = 1'b1;
      end
      check(!seen, "R9", "ack after abort", {31'd0, seen}, 32'd0);
    end

    // R10: back-to-back accesses keep a single select
    access(32'h3000_0040, 7, 1, 2'b01, "R10");
    access(32'h0000_0000, 0, 2, 2'b10, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule